// File: doc/BRIEF.md
# Transmit Abort Jam Controller

This block watches a frame while the serializer sends it and decides whether and when the outgoing data must be replaced by a jam pattern. A frame is opened by a one-cycle `frame_start` pulse. While the frame is open, any of four abort causes, or a collision seen early enough in the frame, raises a jam request. The four causes are a transmit data underrun, loss of clear-to-send, loss of carrier and an exhausted retry budget. The jam is never started before the preamble has been fully sent. A request raised earlier is held until `preamble_done` is seen.

During a jam, `jam_en` selects the jam stream and `jam_bit` supplies an alternating pattern that advances on each `bit_tick`. After 32 bit times the jam ends and `jam_done` pulses. Each abort cause is recorded as a sticky bit in a 16-bit status word. Those bits stay set until the next frame starts. Only one jam is produced per frame.

Top module: `tx_jam_ctrl`

## Requirements
- R1: After reset, `jam_en`, `jam_bit` and `jam_done` are 0 and `status` is 16'h0000. `jam_bit` is 0 in every cycle in which `jam_en` is 0.
- R2: An abort cause that is sampled high while a frame is open sets its own sticky status bit. The bit positions are: underrun at bit 8, clear-to-send lost at bit 9, carrier lost at bit 10 and retry limit at bit 12. All other bits stay 0. A set bit stays set after the cause input drops.
- R3: A `frame_start` pulse clears `status` to 0 in the following cycle. It also opens a new frame with no jam active. In that same cycle, `frame_start` takes priority over any cause.
- R4: If an abort cause is sampled while `preamble_done` is high and the frame has not yet jammed, `jam_en` is 1 in the next cycle.
- R5: A request made while `preamble_done` is low is held without jamming. `jam_en` rises in the cycle after `preamble_done` is first sampled high.
- R6: A collision starts a jam only when `bits_left` is greater than 11. With `bits_left` at 11 or below, a collision alone leaves both `jam_en` and `status` unchanged.
- R7: The jam stream starts at 1 and inverts on each `bit_tick`. `jam_en` stays high for exactly 32 ticks and drops in the cycle after the 32nd tick is sampled.
- R8: `jam_done` is a one-cycle pulse. It is high in the same cycle in which `jam_en` first returns to 0 after a jam.
- R9: At most one jam occurs per frame. Causes or collisions after the jam has ended do not restart it, although the cause status bits still latch.
- R10: Before the first `frame_start` after reset, all causes and collisions are ignored: no jam starts and `status` stays 0.
- R11: An abort cause arriving in the same cycle as a suppressed late collision still starts the jam and sets its status bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-cycle pulse that opens a frame and clears status |
| bit_tick | input | 1 | One-cycle strobe per serial bit time |
| preamble_done | input | 1 | High once the preamble has been fully sent |
| collision | input | 1 | Collision detect |
| bits_left | input | 16 | Bits of the frame still to be sent |
| cause_underrun | input | 1 | Transmit data underrun |
| cause_cts_lost | input | 1 | Clear-to-send lost |
| cause_carrier_lost | input | 1 | Carrier lost |
| cause_retry_limit | input | 1 | Retry budget exhausted |
| jam_en | output | 1 | Selects the jam stream in place of frame data |
| jam_bit | output | 1 | Jam pattern bit |
| jam_done | output | 1 | One-cycle pulse at the end of a jam |
| status | output | 16 | Sticky abort-cause bits (8, 9, 10, 12) |

## Verification
Two decisions can land in the same cycle, and the bench provokes both.

The first is late-collision suppression coinciding with an abort cause. The bench drives a collision with `bits_left` at 5 and, in the same cycle, raises the retry-limit cause. The case is judged by requiring `jam_en` in the next cycle and bit 12 set in `status`.

The second is a held request meeting the end of the preamble. The bench shows that `jam_en` stays low for several cycles while the request is pending. It then shows that `jam_en` goes high exactly one cycle after `preamble_done` rises.

The collision threshold is probed on both sides, with `bits_left` at 11 and at 12.

// File: rtl/jamctl_pkg.sv
package jamctl_pkg;

    localparam int STAT_W       = 16;
    localparam int POS_UNDERRUN = 8;
    localparam int POS_CTS      = 9;
    localparam int POS_CARRIER  = 10;
    localparam int POS_RETRY    = 12;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACTIVE,
        ST_PEND,
        ST_JAM,
        ST_SPENT
    } jam_state_t;

    typedef struct packed {
        logic underrun;
        logic cts_lost;
        logic carrier_lost;
        logic retry_limit;
    } abort_cause_t;

    function automatic logic any_cause(input abort_cause_t c);
        return c.underrun | c.cts_lost | c.carrier_lost | c.retry_limit;
    endfunction

    function automatic logic [STAT_W-1:0] place_status(input abort_cause_t c);
        logic [STAT_W-1:0] w;
        w               = '0;
        w[POS_UNDERRUN] = c.underrun;
        w[POS_CTS]      = c.cts_lost;
        w[POS_CARRIER]  = c.carrier_lost;
        w[POS_RETRY]    = c.retry_limit;
        return w;
    endfunction

endpackage

// File: rtl/jamctl_trigger.sv
module jamctl_trigger
    import jamctl_pkg::*;
#(
    parameter int BL_W        = 16,
    parameter int LATE_WINDOW = 11
) (
    input  abort_cause_t    cause,
    input  logic            collision,
    input  logic [BL_W-1:0] bits_left,
    output logic            req
);
    localparam logic [BL_W-1:0] WINDOW = BL_W'(LATE_WINDOW);

    logic early_collision;

    always_comb begin
        early_collision = collision && (bits_left > WINDOW);
        req             = any_cause(cause) | early_collision;
    end

endmodule

// File: rtl/jamctl_status.sv
module jamctl_status
    import jamctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              enable,
    input  abort_cause_t      cause,
    output logic [STAT_W-1:0] status
);
    logic [STAT_W-1:0] status_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            status_q <= '0;
        end else if (enable) begin
            status_q <= status_q | place_status(cause);
        end
    end

    assign status = status_q;

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst)
        !clear |=> ((status_q & $past(status_q)) == $past(status_q))); // R2

endmodule

// File: rtl/jamctl_seq.sv
module jamctl_seq #(
    parameter int JAM_BITS = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic bit_tick,
    output logic last,
    output logic pattern
);
    localparam int CNT_W = $clog2(JAM_BITS) + 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(JAM_BITS - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            cnt_q <= '0;
        end else if (bit_tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        last    = active && bit_tick && (cnt_q == LAST_IDX);
        pattern = active && !cnt_q[0];
    end

    AST_SEQ_BOUND: assert property (@(posedge clk) disable iff (rst)
        active |-> (cnt_q <= LAST_IDX)); // R7

endmodule

// File: rtl/tx_jam_ctrl.sv
module tx_jam_ctrl
    import jamctl_pkg::*;
#(
    parameter int BL_W        = 16,
    parameter int LATE_WINDOW = 11,
    parameter int JAM_BITS    = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic              bit_tick,
    input  logic              preamble_done,
    input  logic              collision,
    input  logic [BL_W-1:0]   bits_left,
    input  logic              cause_underrun,
    input  logic              cause_cts_lost,
    input  logic              cause_carrier_lost,
    input  logic              cause_retry_limit,
    output logic              jam_en,
    output logic              jam_bit,
    output logic              jam_done,
    output logic [STAT_W-1:0] status
);
    jam_state_t   state_q;
    abort_cause_t cause;
    logic         req;
    logic         seq_last;
    logic         seq_pattern;
    logic         done_q;
    logic         in_jam;
    logic         stat_en;

    always_comb begin
        cause.underrun     = cause_underrun;
        cause.cts_lost     = cause_cts_lost;
        cause.carrier_lost = cause_carrier_lost;
        cause.retry_limit  = cause_retry_limit;
        in_jam             = (state_q == ST_JAM);
        stat_en            = (state_q != ST_IDLE) && !frame_start;
    end

    jamctl_trigger #(
        .BL_W        (BL_W),
        .LATE_WINDOW (LATE_WINDOW)
    ) u_trigger (
        .cause     (cause),
        .collision (collision),
        .bits_left (bits_left),
        .req       (req)
    );

    jamctl_status u_status (
        .clk    (clk),
        .rst    (rst),
        .clear  (frame_start),
        .enable (stat_en),
        .cause  (cause),
        .status (status)
    );

    jamctl_seq #(
        .JAM_BITS (JAM_BITS)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .active   (in_jam),
        .bit_tick (bit_tick),
        .last     (seq_last),
        .pattern  (seq_pattern)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (frame_start) begin
                state_q <= ST_ACTIVE;
            end else begin
                case (state_q)
                    ST_ACTIVE: begin
                        if (req) state_q <= preamble_done ? ST_JAM : ST_PEND;
                    end
                    ST_PEND: begin
                        if (preamble_done) state_q <= ST_JAM;
                    end
                    ST_JAM: begin
                        if (seq_last) begin
                            state_q <= ST_SPENT;
                            done_q  <= 1'b1;
                        end
                    end
                    default: state_q <= state_q;
                endcase
            end
        end
    end

    assign jam_en   = in_jam;
    assign jam_bit  = seq_pattern;
    assign jam_done = done_q;

    AST_JAM_AFTER_PREAMBLE: assert property (@(posedge clk) disable iff (rst)
        $rose(jam_en) |-> $past(preamble_done)); // R5

    AST_DONE_ENDS_JAM: assert property (@(posedge clk) disable iff (rst)
        jam_done |-> (!jam_en && $past(jam_en))); // R8

    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !jam_en |-> !jam_bit); // R1

    AST_LATE_COLLISION_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ACTIVE && !frame_start && collision &&
         bits_left <= BL_W'(LATE_WINDOW) && !any_cause(cause)) |=> !jam_en); // R6

    AST_ONE_JAM: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SPENT && !frame_start) |=> !jam_en); // R9

endmodule

// File: tb/tx_jam_ctrl_bench.sv
module tx_jam_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_start = 1'b0;
    logic        bit_tick = 1'b0;
    logic        preamble_done = 1'b0;
    logic        collision = 1'b0;
    logic [15:0] bits_left = 16'd1000;
    logic        c_under = 1'b0;
    logic        c_cts = 1'b0;
    logic        c_carr = 1'b0;
    logic        c_retry = 1'b0;
    logic        jam_en;
    logic        jam_bit;
    logic        jam_done;
    logic [15:0] status;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    tx_jam_ctrl u_tx_jam_ctrl (
        .clk                (clk),
        .rst                (rst),
        .frame_start        (frame_start),
        .bit_tick           (bit_tick),
        .preamble_done      (preamble_done),
        .collision          (collision),
        .bits_left          (bits_left),
        .cause_underrun     (c_under),
        .cause_cts_lost     (c_cts),
        .cause_carrier_lost (c_carr),
        .cause_retry_limit  (c_retry),
        .jam_en             (jam_en),
        .jam_bit            (jam_bit),
        .jam_done           (jam_done),
        .status             (status)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic open_frame(input logic pd);
        frame_start   = 1'b1;
        preamble_done = pd;
        step();
        frame_start = 1'b0;
    endtask

    task automatic run_jam(input string req);
        for (int i = 0; i < 32; i++) begin
            check(req, "jam_en during jam", int'(jam_en), 1);
            check(req, "jam_bit pattern", int'(jam_bit), (i % 2 == 0) ? 1 : 0);
            check("R8", "no early done", int'(jam_done), 0);
            bit_tick = 1'b1;
            step();
            bit_tick = 1'b0;
            if (i < 31) step();
        end
        check(req, "jam_en after 32 ticks", int'(jam_en), 0);
        check("R8", "done pulse", int'(jam_done), 1);
        check("R1", "jam_bit quiet", int'(jam_bit), 0);
        step();
        check("R8", "done single cycle", int'(jam_done), 0);
    endtask

    task automatic t_reset();
        check("R1", "jam_en at reset", int'(jam_en), 0);
        check("R1", "jam_bit at reset", int'(jam_bit), 0);
        check("R1", "jam_done at reset", int'(jam_done), 0);
        check("R1", "status at reset", int'(status), 0);
        c_under = 1'b1; collision = 1'b1; preamble_done = 1'b1;
        step(); step();
        c_under = 1'b0; collision = 1'b0;
        step();
        check("R10", "no jam before frame", int'(jam_en), 0);
        check("R10", "no status before frame", int'(status), 0);
    endtask

    task automatic one_cause(input int sel, input int exp_word);
        open_frame(1'b0);
        check("R3", "status cleared", int'(status), 0);
        check("R3", "no jam on open", int'(jam_en), 0);
        case (sel)
            0: c_under = 1'b1;
            1: c_cts   = 1'b1;
            2: c_carr  = 1'b1;
            default: c_retry = 1'b1;
        endcase
        step();
        c_under = 1'b0; c_cts = 1'b0; c_carr = 1'b0; c_retry = 1'b0;
        check("R2", "cause bit", int'(status), exp_word);
        step(); step();
        check("R2", "cause bit sticky", int'(status), exp_word);
    endtask

    task automatic t_cause_bits();
        one_cause(0, 16'h0100);
        one_cause(1, 16'h0200);
        one_cause(2, 16'h0400);
        one_cause(3, 16'h1000);
        frame_start = 1'b1; c_under = 1'b1;
        step();
        frame_start = 1'b0; c_under = 1'b0;
        check("R3", "frame_start wins over cause", int'(status), 0);
    endtask

    task automatic t_abort_direct();
        open_frame(1'b1);
        c_carr = 1'b1;
        step();
        c_carr = 1'b0;
        check("R4", "jam next cycle", int'(jam_en), 1);
        run_jam("R7");
    endtask

    task automatic t_pending();
        open_frame(1'b0);
        c_cts = 1'b1;
        step();
        c_cts = 1'b0;
        for (int i = 0; i < 5; i++) step();
        check("R5", "held while preamble", int'(jam_en), 0);
        preamble_done = 1'b1;
        step();
        check("R5", "jam after preamble", int'(jam_en), 1);
        run_jam("R7");
    endtask

    task automatic t_collision();
        open_frame(1'b1);
        bits_left = 16'd11; collision = 1'b1;
        step();
        collision = 1'b0;
        check("R6", "late collision no jam", int'(jam_en), 0);
        step();
        check("R6", "late collision still no jam", int'(jam_en), 0);
        check("R6", "late collision no status", int'(status), 0);
        bits_left = 16'd12; collision = 1'b1;
        step();
        collision = 1'b0; bits_left = 16'd1000;
        check("R6", "early collision jams", int'(jam_en), 1);
        run_jam("R7");
    endtask

    task automatic t_overlap();
        open_frame(1'b1);
        bits_left = 16'd5; collision = 1'b1; c_retry = 1'b1;
        step();
        collision = 1'b0; c_retry = 1'b0; bits_left = 16'd1000;
        check("R11", "abort beside late collision jams", int'(jam_en), 1);
        check("R11", "retry bit set", int'(status), 16'h1000);
        run_jam("R7");
    endtask

    task automatic t_once();
        c_under = 1'b1; collision = 1'b1;
        step();
        c_under = 1'b0; collision = 1'b0;
        for (int i = 0; i < 4; i++) begin
            check("R9", "no second jam", int'(jam_en), 0);
            step();
        end
        check("R9", "status still latches", int'(status), 16'h1100);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        step(); step();
        rst = 1'b0;
        step();
        t_reset();
        t_cause_bits();
        t_abort_direct();
        t_pending();
        t_collision();
        t_overlap();
        t_once();
        summary();
    end

endmodule